// File: doc/BRIEF.md
# Indexed Byte Window Adapter for a Shared Peripheral Bus

This block lets a host reach the byte-wide memory of up to sixteen peripherals through four host-visible registers. The registers are a pointer, a data port, a mailbox and a status/control word. The 16-bit pointer is split in two. Its top four bits choose the peripheral, and its low twelve bits choose a byte inside that peripheral's 4 KB window.

The data port always holds a prefetched copy of the byte under the pointer. Reading the port returns that copy. Writing the port stores the byte on the bus. After every data-port access the pointer moves forward by one, and the byte at the new location is fetched again. The adapter never refetches on its own: a new fetch happens only when the pointer changes.

Peripherals signal the host by writing to offset 0x001 of any window. The adapter accepts one such post at a time and then locks. Further posts are refused until the host reads the mailbox.

The host port is a valid/ready port. A transfer happens on a clock edge where both `hst_valid` and `hst_ready` are high. Read data on `hst_rdata` is valid during that same cycle. While `hst_ready` is low, the host must hold `hst_valid`, `hst_sel`, `hst_write` and `hst_wdata` unchanged.

The bus master side issues one cycle at a time. It holds `mst_req` and all of its qualifiers steady until `mst_done` is seen. An external arbiter grants the bus, and it gives the host priority whenever the current cycle ends.

The bus slave side answers with `slv_done` in the same cycle as a post it accepts.

Register select codes are: 0 pointer, 1 data port, 2 mailbox, 3 status/control.

Top module: `win_adapter`

## Requirements
- R1: After reset the pointer is 0x0000, the host interrupt is low, the mailbox is unlocked, and a bus read of address 0x0000 is already requested (`mst_req`=1, `mst_we`=0).
- R2: Writing the pointer (select 0) loads it and starts a bus read at the new address. When that read completes, the data port (select 1) returns the fetched byte in bits 7:0, with bits 15:8 zero.
- R3: A host read of the data port returns the prefetched byte. The pointer then becomes the old value plus one, and a bus read at the new pointer follows.
- R4: A host write to the data port produces a bus write of `hst_wdata[7:0]` at the old pointer. It is followed by a bus read at the old pointer plus one, which becomes the new pointer.
- R5: The pointer counts modulo 2^16. A step from 0x0FFF gives 0x1000, which moves to the next peripheral. A step from 0xFFFF gives 0x0000.
- R6: While a bus cycle is outstanding, host accesses to select 0 or 1 are held off with `hst_ready` low. They complete, with correct data, once the bus cycle finishes.
- R7: An unlocked mailbox accepts a slave write whose address bits 11:0 equal 0x001. It raises `slv_done` in that cycle and captures the result as {address bits 15:12, data byte}. A mailbox read returns that value in bits 11:0, and the mailbox becomes locked.
- R8: While the mailbox is locked, posts get no `slv_done` and its contents do not change. Slave writes to any other offset never get `slv_done`.
- R9: A host read of the mailbox clears the lock and the pending flag in the same cycle. A post in the next cycle is accepted.
- R10: Status read bits: bit 0 is data-valid (no bus cycle outstanding), bit 1 is interrupt pending, and bit 2 is interrupt enable. A status write sets the enable from bit 2. `host_irq` = pending AND enable. Host writes to the mailbox have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hst_valid | input | 1 | Host access request |
| hst_ready | output | 1 | Host access may complete this cycle |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_sel | input | 2 | Register select |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid when valid and ready |
| host_irq | output | 1 | Interrupt to host |
| mst_req | output | 1 | Bus cycle request |
| mst_we | output | 1 | Bus cycle is a write |
| mst_addr | output | 16 | Bus address |
| mst_wdata | output | 8 | Bus write byte |
| mst_done | input | 1 | Bus cycle complete |
| mst_rdata | input | 8 | Bus read byte, valid with mst_done |
| slv_req | input | 1 | Incoming bus cycle |
| slv_we | input | 1 | Incoming cycle is a write |
| slv_addr | input | 16 | Incoming address |
| slv_wdata | input | 8 | Incoming byte |
| slv_done | output | 1 | Post accepted |

## Verification
A wrong pointer shows up within one refetch. It appears as a bus address, or as a data-port byte, that does not match the pointer plus the count of accesses made. A fetch state that is stuck or skipped appears as `hst_ready` stalled forever, or as stale data returned at once. A wrong lock state shows on the very next post, as a missing or extra `slv_done`, or as a mailbox value that changed while it should have held.

// File: rtl/win_pkg.sv
package win_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } win_state_e;

  localparam logic [1:0] SEL_PTR  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_MBOX = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/win_window.sv
module win_window #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_wr,
  input  logic [ADDR_W-1:0] ptr_wval,
  input  logic              dat_rd,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_wval,
  output logic              idle,
  output logic [ADDR_W-1:0] ptr,
  output logic [DATA_W-1:0] dbuf,
  output logic              mst_req,
  output logic              mst_we,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [DATA_W-1:0] mst_wdata,
  input  logic              mst_done,
  input  logic [DATA_W-1:0] mst_rdata
);
  import win_pkg::*;

  win_state_e        state;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wbyte;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FETCH;
      ptr     <= '0;
      wr_addr <= '0;
      dbuf    <= '0;
      wbyte   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ptr_wr) begin
            ptr   <= ptr_wval;
            state <= ST_FETCH;
          end else if (dat_rd) begin
            ptr   <= ptr + 1'b1;
            state <= ST_FETCH;
          end else if (dat_wr) begin
            wr_addr <= ptr;
            wbyte   <= dat_wval;
            ptr     <= ptr + 1'b1;
            state   <= ST_STORE;
          end
        end
        ST_FETCH: if (mst_done) begin
          dbuf  <= mst_rdata;
          state <= ST_IDLE;
        end
        ST_STORE: if (mst_done) state <= ST_FETCH;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state == ST_IDLE);
  assign mst_req   = (state != ST_IDLE);
  assign mst_we    = (state == ST_STORE);
  assign mst_addr  = (state == ST_STORE) ? wr_addr : ptr;
  assign mst_wdata = wbyte;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mst_req && !mst_done) |=> (mst_req && $stable(mst_addr) && $stable(mst_we))); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (idle && (dat_rd || dat_wr) && !ptr_wr) |=> (ptr == $past(ptr) + 1'b1)); // R3
  AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    (mst_req && mst_we && mst_done) |=> (mst_req && !mst_we)); // R4
endmodule

// File: rtl/win_mailbox.sv
module win_mailbox #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 4,
  parameter int POST_OFS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slv_req,
  input  logic              slv_we,
  input  logic [ADDR_W-1:0] slv_addr,
  input  logic [DATA_W-1:0] slv_wdata,
  output logic              slv_done,
  input  logic              clr,
  output logic              locked,
  output logic [SEL_W-1:0]  sender,
  output logic [DATA_W-1:0] mbyte
);
  localparam int LOW_W = ADDR_W - SEL_W;

  logic hit;
  assign hit      = slv_req && slv_we &&
                    (slv_addr[LOW_W-1:0] == LOW_W'(POST_OFS));
  assign slv_done = hit && !locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      sender <= '0;
      mbyte  <= '0;
    end else if (slv_done) begin
      locked <= 1'b1;
      sender <= slv_addr[ADDR_W-1:LOW_W];
      mbyte  <= slv_wdata;
    end else if (clr) begin
      locked <= 1'b0;
    end
  end

  AST_ACK_LOCKS: assert property (@(posedge clk) disable iff (rst)
    slv_done |=> locked); // R7
  AST_HELD: assert property (@(posedge clk) disable iff (rst)
    (locked && !clr) |=> ($stable(mbyte) && $stable(sender) && locked)); // R8
  AST_CLR_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (locked && clr) |=> !locked); // R9
endmodule

// File: rtl/win_adapter.sv
module win_adapter #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 4,
  parameter int POST_OFS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_valid,
  output logic              hst_ready,
  input  logic              hst_write,
  input  logic [1:0]        hst_sel,
  input  logic [ADDR_W-1:0] hst_wdata,
  output logic [ADDR_W-1:0] hst_rdata,
  output logic              host_irq,
  output logic              mst_req,
  output logic              mst_we,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [DATA_W-1:0] mst_wdata,
  input  logic              mst_done,
  input  logic [DATA_W-1:0] mst_rdata,
  input  logic              slv_req,
  input  logic              slv_we,
  input  logic [ADDR_W-1:0] slv_addr,
  input  logic [DATA_W-1:0] slv_wdata,
  output logic              slv_done
);
  import win_pkg::*;

  logic              idle, locked, ien, acc;
  logic              ptr_wr, dat_rd, dat_wr, mb_clr, st_wr;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] dbuf, mbyte;
  logic [SEL_W-1:0]  sender;

  assign hst_ready = (hst_sel == SEL_PTR || hst_sel == SEL_DATA) ? idle : 1'b1;
  assign acc       = hst_valid && hst_ready;
  assign ptr_wr    = acc &&  hst_write && (hst_sel == SEL_PTR);
  assign dat_rd    = acc && !hst_write && (hst_sel == SEL_DATA);
  assign dat_wr    = acc &&  hst_write && (hst_sel == SEL_DATA);
  assign mb_clr    = acc && !hst_write && (hst_sel == SEL_MBOX);
  assign st_wr     = acc &&  hst_write && (hst_sel == SEL_STAT);

  win_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_window (
    .clk(clk), .rst(rst),
    .ptr_wr(ptr_wr), .ptr_wval(hst_wdata),
    .dat_rd(dat_rd), .dat_wr(dat_wr), .dat_wval(hst_wdata[DATA_W-1:0]),
    .idle(idle), .ptr(ptr), .dbuf(dbuf),
    .mst_req(mst_req), .mst_we(mst_we), .mst_addr(mst_addr),
    .mst_wdata(mst_wdata), .mst_done(mst_done), .mst_rdata(mst_rdata)
  );

  win_mailbox #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
                .POST_OFS(POST_OFS)) u_mailbox (
    .clk(clk), .rst(rst),
    .slv_req(slv_req), .slv_we(slv_we), .slv_addr(slv_addr),
    .slv_wdata(slv_wdata), .slv_done(slv_done),
    .clr(mb_clr), .locked(locked), .sender(sender), .mbyte(mbyte)
  );

  always_ff @(posedge clk) begin
    if (rst)        ien <= 1'b0;
    else if (st_wr) ien <= hst_wdata[2];
  end

  assign host_irq = locked && ien;

  always_comb begin
    case (hst_sel)
      SEL_PTR:  hst_rdata = ptr;
      SEL_DATA: hst_rdata = ADDR_W'(dbuf);
      SEL_MBOX: hst_rdata = ADDR_W'({sender, mbyte});
      default:  hst_rdata = ADDR_W'({ien, locked, idle});
    endcase
  end

  AST_DATA_STALL: assert property (@(posedge clk) disable iff (rst)
    (hst_valid && hst_sel == SEL_DATA && mst_req) |-> !hst_ready); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mb_clr && !slv_done) |=> !host_irq); // R9
endmodule

// File: tb/tb_win_adapter.sv
module tb_win_adapter;
  logic        clk = 0, rst = 1;
  logic        hst_valid = 0, hst_write = 0, hst_ready, host_irq;
  logic [1:0]  hst_sel = 0;
  logic [15:0] hst_wdata = 0, hst_rdata;
  logic        mst_req, mst_we, mst_done = 0;
  logic [15:0] mst_addr;
  logic [7:0]  mst_wdata, mst_rdata = 0;
  logic        slv_req = 0, slv_we = 0, slv_done;
  logic [15:0] slv_addr = 0;
  logic [7:0]  slv_wdata = 0;
  int total = 0, bad = 0, cnt = 0;
  logic [15:0] last_waddr = 0;
  logic [7:0]  last_wdata = 0;

  always #2 clk = ~clk;

  win_adapter dut (.*);

  function automatic logic [7:0] fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // bus memory model: done three cycles into a request
  always @(posedge clk) begin
    if (rst) begin
      mst_done <= 0; cnt <= 0;
    end else if (mst_done) begin
      mst_done <= 0;
    end else if (mst_req) begin
      if (cnt == 2) begin
        mst_done  <= 1;
        mst_rdata <= fn(mst_addr);
        if (mst_we) begin last_waddr <= mst_addr; last_wdata <= mst_wdata; end
        cnt <= 0;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host(input logic [1:0] s, input logic w, input logic [15:0] d,
                      output logic [15:0] r, output int stall);
    @(negedge clk);
    hst_valid = 1; hst_sel = s; hst_write = w; hst_wdata = d; stall = 0;
    #1;
    while (!hst_ready) begin @(negedge clk); #1; stall++; end
    r = hst_rdata;
    @(posedge clk); #1 hst_valid = 0;
  endtask

  task automatic wait_valid();
    logic [15:0] r; int st;
    do host(2'd3, 0, 0, r, st); while (!r[0]);
  endtask

  task automatic post(input logic [15:0] a, input logic [7:0] d, output logic ack);
    @(negedge clk);
    slv_req = 1; slv_we = 1; slv_addr = a; slv_wdata = d;
    #1 ack = slv_done;
    @(posedge clk); #1 slv_req = 0;
  endtask

  // {pointer, expected byte, pointer after one data read}
  localparam logic [39:0] VEC [4] = '{
    {16'h1234, 8'h7C, 16'h1235},
    {16'h0FFF, 8'hAA, 16'h1000},
    {16'hFFFF, 8'h5A, 16'h0000},
    {16'hA001, 8'hFB, 16'hA002}
  };

  initial begin
    logic [15:0] r; int st; logic ack;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    chk("R1 req after reset", {15'd0, mst_req}, 16'd1);
    chk("R1 addr after reset", mst_addr, 16'h0000);
    chk("R1 we after reset", {15'd0, mst_we}, 16'd0);
    chk("R1 irq after reset", {15'd0, host_irq}, 16'd0);
    wait_valid();
    host(2'd0, 0, 0, r, st); chk("R1 pointer after reset", r, 16'h0000);

    foreach (VEC[i]) begin
      host(2'd0, 1, VEC[i][39:24], r, st);
      wait_valid();
      host(2'd1, 0, 0, r, st); chk("R2/R3 data byte", r, {8'h00, VEC[i][23:16]});
      host(2'd0, 0, 0, r, st); chk("R3/R5 pointer step", r, VEC[i][15:0]);
      host(2'd1, 0, 0, r, st); chk("R3/R5 refetched byte", r, {8'h00, fn(VEC[i][15:0])});
    end

    // R6: data read right after pointer write is held off
    host(2'd0, 1, 16'h4444, r, st);
    host(2'd1, 0, 0, r, st);
    chk("R6 stalled", {15'd0, st > 0}, 16'd1);
    chk("R6 data after stall", r, {8'h00, fn(16'h4444)});

    // R4: data write
    host(2'd0, 1, 16'h2010, r, st);
    wait_valid();
    host(2'd1, 1, 16'h0099, r, st);
    wait_valid();
    chk("R4 write addr", last_waddr, 16'h2010);
    chk("R4 write byte", {8'h00, last_wdata}, 16'h0099);
    host(2'd0, 0, 0, r, st); chk("R4 pointer", r, 16'h2011);
    host(2'd1, 0, 0, r, st); chk("R4 refetch", r, {8'h00, fn(16'h2011)});

    // mailbox
    post(16'h3001, 8'h42, ack); chk("R7 ack", {15'd0, ack}, 16'd1);
    host(2'd3, 0, 0, r, st); chk("R10 pending no enable", {13'd0, r[2:0]} & 16'h6, 16'h2);
    chk("R10 irq masked", {15'd0, host_irq}, 16'd0);
    host(2'd3, 1, 16'h0004, r, st);
    chk("R10 irq enabled", {15'd0, host_irq}, 16'd1);
    post(16'h5001, 8'h77, ack); chk("R8 locked no ack", {15'd0, ack}, 16'd0);
    post(16'h6002, 8'h11, ack); chk("R8 other offset no ack", {15'd0, ack}, 16'd0);
    host(2'd2, 1, 16'hFFFF, r, st);
    host(2'd2, 0, 0, r, st); chk("R7/R8/R10 mailbox value", r, 16'h0342);
    chk("R9 irq cleared", {15'd0, host_irq}, 16'd0);
    host(2'd3, 0, 0, r, st); chk("R9 pending cleared", {15'd0, r[1]}, 16'd0);
    post(16'h5001, 8'h77, ack); chk("R9 post accepted", {15'd0, ack}, 16'd1);
    host(2'd2, 0, 0, r, st); chk("R9 new value", r, 16'h0577);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule